// File: doc/BRIEF.md
# Two-Wire Bus Idle and Clock-Stall Watchdog

This block watches the already synchronized clock and data lines of a two-wire SMBus-style interface and turns their levels into three timing events. The first is bus idle: once both lines have stayed high long enough, a sticky flag says the bus may be claimed. The second is a request to launch a master START. It is held pending until the bus is seen idle and is then released as a single-cycle strobe. The third is a clock-stall timeout: the clock line has been held low for too long, and a one-cycle pulse tells the controller to reset its interface.

Time is measured in strobes from the selected clock-source timer, not in cycles of `clk`. The idle threshold is strict. The flag rises only after FREE_TICKS+1 strobes have been seen with both lines high. The first strobe may close a partial period, so FREE_TICKS+1 strobes guarantee that more than FREE_TICKS whole periods have passed. With FREE_TICKS = 10 and a strobe period of at least 5 µs, this covers the 50 µs bus-free time. With that period, the default LOW_TICKS of 5000 gives a clock-stall limit of about 25 ms. Idle detection depends on the strobe even when the interface only ever acts as a slave.

Top module: `smb_idle_watch`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `bus_free`, `start_go`, `start_wait` and `low_tmo` are all 0.
- R2: With `en` and `free_en` high and both `scl` and `sda` high, `bus_free` goes to 1 after the clock edge that samples the (FREE_TICKS+1)-th `tick` of that high stretch. It stays 0 after the FREE_TICKS-th tick.
- R3: A clock edge that samples `scl` or `sda` low clears the idle tick count and `bus_free`. Counting then starts again from zero.
- R4: Once `bus_free` is 1, it holds while both lines stay high and both enables stay set. Further ticks neither clear it nor wrap the count.
- R5: When `start_wait` and `bus_free` are both 1, `start_go` is 1 for exactly one cycle, and `start_wait` is 0 after the next edge.
- R6: A `start_req` sampled high sets `start_wait` from the next cycle. A request sampled in the same cycle as `start_go` is absorbed by that launch.
- R7: With `en` and `low_en` high and `scl` low, `low_tmo` pulses high for one cycle after the edge that samples the LOW_TICKS-th `tick` of the low stretch. No further pulse occurs until `scl` has been sampled high.
- R8: An edge that samples `scl` high restarts the clock-low count, so low stretches separated by a high level never add up.
- R9: An edge that samples `en` low clears both counts, `bus_free`, `start_wait` and `low_tmo`.
- R10: With `free_en` low, `bus_free` stays 0. With `low_en` low, `low_tmo` stays 0.
- R11: Cycles without `tick` do not advance either count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Interface enable; low clears all state |
| free_en | input | 1 | Enables idle-bus detection |
| low_en | input | 1 | Enables clock-stall detection |
| tick | input | 1 | One-cycle strobe from the clock-source timer |
| scl | input | 1 | Synchronized clock line level |
| sda | input | 1 | Synchronized data line level |
| start_req | input | 1 | Request to launch a master START |
| bus_free | output | 1 | Bus idle flag |
| start_wait | output | 1 | A START request is pending |
| start_go | output | 1 | One-cycle START launch strobe |
| low_tmo | output | 1 | One-cycle clock-stall timeout pulse |

## Verification
If the idle count is off by even one step, `bus_free` rises one tick too early or too late. The same error moves any pending `start_go`, and it shows within FREE_TICKS+1 ticks of the lines going high. A bad clock-low count, or one that fails to restart, moves or repeats `low_tmo` within LOW_TICKS ticks of a low stretch. A corrupted pending flag shows at the next idle bus as a missing, repeated or stretched launch strobe. An enable that does not clear state leaves an output high on the cycle after `en` falls.

// File: rtl/smb_idle_pkg.sv
package smb_idle_pkg;

  typedef struct packed {
    logic scl;
    logic sda;
    logic tick;
  } smb_lines_t;

  // both wires released: the only level pair that counts toward idle
  function automatic logic lines_high(input smb_lines_t l);
    return l.scl & l.sda;
  endfunction

  // a timer strobe seen while both lines are high
  function automatic logic idle_step(input smb_lines_t l);
    return l.scl & l.sda & l.tick;
  endfunction

endpackage

// File: rtl/smb_free_det.sv
module smb_free_det
  import smb_idle_pkg::*;
#(
  parameter int unsigned FREE_TICKS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  smb_lines_t lines,
  output logic       bus_free,
  output logic       free_hit
);

  localparam int unsigned FREE_LIM = FREE_TICKS + 1;
  localparam int          CW       = $clog2(FREE_LIM + 1);

  logic [CW-1:0] cnt;

  // true when the count sits one strobe short of the strict threshold
  function automatic logic last_step(input logic [CW-1:0] c);
    return c == CW'(FREE_LIM - 1);
  endfunction

  assign free_hit = run & idle_step(lines) & ~bus_free & last_step(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      bus_free <= 1'b0;
    end else if (!run || !lines_high(lines)) begin
      cnt      <= '0;
      bus_free <= 1'b0;
    end else if (lines.tick && !bus_free) begin
      cnt <= cnt + CW'(1);
      if (free_hit) bus_free <= 1'b1;
    end
  end

endmodule

// File: rtl/smb_low_det.sv
module smb_low_det #(
  parameter int unsigned LOW_TICKS = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic scl,
  input  logic tick,
  output logic low_tmo,
  output logic low_hit
);

  localparam int CW = $clog2(LOW_TICKS + 1);

  logic [CW-1:0] cnt;

  function automatic logic at_limit(input logic [CW-1:0] c);
    return c == CW'(LOW_TICKS);
  endfunction

  function automatic logic one_short(input logic [CW-1:0] c);
    return c == CW'(LOW_TICKS - 1);
  endfunction

  assign low_hit = run & ~scl & tick & one_short(cnt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      low_tmo <= 1'b0;
    end else begin
      low_tmo <= low_hit;
      if (!run || scl) cnt <= '0;
      else if (tick && !at_limit(cnt)) cnt <= cnt + CW'(1);
    end
  end

endmodule

// File: rtl/smb_start_ctl.sv
module smb_start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic start_req,
  input  logic bus_free,
  output logic start_wait,
  output logic start_go
);

  assign start_go = start_wait & bus_free;

  always_ff @(posedge clk) begin
    if (!rst_n)         start_wait <= 1'b0;
    else if (!en)       start_wait <= 1'b0;
    else if (start_go)  start_wait <= 1'b0;
    else if (start_req) start_wait <= 1'b1;
  end

endmodule

// File: rtl/smb_idle_watch.sv
module smb_idle_watch
  import smb_idle_pkg::*;
#(
  parameter int unsigned FREE_TICKS = 10,
  parameter int unsigned LOW_TICKS  = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic free_en,
  input  logic low_en,
  input  logic tick,
  input  logic scl,
  input  logic sda,
  input  logic start_req,
  output logic bus_free,
  output logic start_wait,
  output logic start_go,
  output logic low_tmo
);

  smb_lines_t lines;
  logic       free_run;
  logic       low_run;
  logic       free_hit;
  logic       low_hit;

  assign lines    = '{scl: scl, sda: sda, tick: tick};
  assign free_run = en & free_en;
  assign low_run  = en & low_en;

  smb_free_det #(.FREE_TICKS(FREE_TICKS)) u_free (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (free_run),
    .lines    (lines),
    .bus_free (bus_free),
    .free_hit (free_hit)
  );

  smb_low_det #(.LOW_TICKS(LOW_TICKS)) u_low (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (low_run),
    .scl     (scl),
    .tick    (tick),
    .low_tmo (low_tmo),
    .low_hit (low_hit)
  );

  smb_start_ctl u_start (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .start_req  (start_req),
    .bus_free   (bus_free),
    .start_wait (start_wait),
    .start_go   (start_go)
  );

endmodule

// File: rtl/smb_idle_watch_chk.sv
module smb_idle_watch_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic free_en,
  input logic low_en,
  input logic tick,
  input logic scl,
  input logic sda,
  input logic bus_free,
  input logic start_wait,
  input logic start_go,
  input logic low_tmo,
  input logic free_hit,
  input logic low_hit
);

  // R2
  free_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_hit |=> bus_free);

  // R2
  free_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> $past(tick) && $past(free_hit));

  // R3
  free_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl || !sda) |=> !bus_free);

  // R4
  free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_free && scl && sda && en && free_en) |=> bus_free);

  // R5
  go_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> !start_go && !start_wait);

  // R7
  low_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_tmo |=> !low_tmo);

  // R7
  low_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_tmo |-> $past(tick) && !$past(scl) && $past(low_hit));

  // R9
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_free && !start_wait && !low_tmo);

  // R10
  free_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !free_en |=> !bus_free);

  // R10
  low_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !low_en |=> !low_tmo);

endmodule

bind smb_idle_watch smb_idle_watch_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .free_en    (free_en),
  .low_en     (low_en),
  .tick       (tick),
  .scl        (scl),
  .sda        (sda),
  .bus_free   (bus_free),
  .start_wait (start_wait),
  .start_go   (start_go),
  .low_tmo    (low_tmo),
  .free_hit   (free_hit),
  .low_hit    (low_hit)
);

// File: tb/test_smb_idle_watch.sv
module test_smb_idle_watch;

  localparam int CLK_PERIOD = 10;
  localparam int FT = 10;
  localparam int LT = 5000;

  logic clk = 1'b0;
  logic rst_n, en, free_en, low_en, tick, scl, sda, start_req;
  logic bus_free, start_wait, start_go, low_tmo;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smb_idle_watch #(.FREE_TICKS(FT), .LOW_TICKS(LT)) i_smb_idle_watch (
    .clk(clk), .rst_n(rst_n), .en(en), .free_en(free_en), .low_en(low_en),
    .tick(tick), .scl(scl), .sda(sda), .start_req(start_req),
    .bus_free(bus_free), .start_wait(start_wait), .start_go(start_go),
    .low_tmo(low_tmo)
  );

  // ---- behavioural reference, written from the requirements ----
  int m_idle, m_lowc;
  bit m_free, m_pend, m_tmo;

  function automatic bit idle_reached(int ticks_seen);
    return ticks_seen > FT;          // strictly more than FT periods
  endfunction

  function automatic bit stall_reached(int ticks_seen);
    return ticks_seen == LT;
  endfunction

  always @(posedge clk) begin
    bit launch;
    launch = m_pend & m_free;
    if (!rst_n || !en) begin
      m_idle = 0; m_free = 0; m_pend = 0; m_lowc = 0; m_tmo = 0;
    end else begin
      if (!free_en || !scl || !sda) begin
        m_idle = 0; m_free = 0;
      end else if (tick && !m_free) begin
        m_idle++;
        m_free = idle_reached(m_idle);
      end
      if (launch) m_pend = 0;
      else if (start_req) m_pend = 1;
      m_tmo = 0;
      if (!low_en || scl) m_lowc = 0;
      else if (tick && m_lowc < LT) begin
        m_lowc++;
        m_tmo = stall_reached(m_lowc);
      end
    end
  end

  task automatic want(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    want("R2", "bus_free",   bus_free,   m_free);
    want("R6", "start_wait", start_wait, m_pend);
    want("R5", "start_go",   start_go,   m_pend & m_free);
    want("R7", "low_tmo",    low_tmo,    m_tmo);
  endtask

  // one clock: inputs already set, sample at the following falling edge
  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare_model();
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    int seed;
    rst_n = 0; en = 1; free_en = 1; low_en = 1;
    tick = 0; scl = 1; sda = 1; start_req = 0;
    seed = $urandom(32'h5eed);
    repeat (3) @(negedge clk);
    // R1: reset state
    want("R1", "bus_free", bus_free, 1'b0);
    want("R1", "start_go", start_go, 1'b0);
    want("R1", "low_tmo",  low_tmo,  1'b0);
    rst_n = 1;
    cyc();
    want("R1", "start_wait", start_wait, 1'b0);

    // R2: strict threshold, R4: saturation
    tick = 1;
    cyc(FT);
    want("R2", "bus_free after FT ticks", bus_free, 1'b0);
    cyc();
    want("R2", "bus_free after FT+1 ticks", bus_free, 1'b1);
    cyc(40);
    want("R4", "bus_free held", bus_free, 1'b1);

    // R3: a low data level clears
    sda = 0; cyc(); sda = 1;
    want("R3", "bus_free after sda low", bus_free, 1'b0);

    // R11: no ticks, no progress
    tick = 0; cyc(50);
    want("R11", "bus_free without ticks", bus_free, 1'b0);

    // R6 / R5: pending request launched on idle
    start_req = 1; cyc(); start_req = 0;
    want("R6", "start_wait set", start_wait, 1'b1);
    tick = 1; cyc(FT);
    want("R5", "no launch before idle", start_go, 1'b0);
    cyc();
    want("R5", "launch on idle", start_go, 1'b1);
    start_req = 1; cyc(); start_req = 0;
    want("R5", "launch one cycle", start_go, 1'b0);
    want("R6", "request absorbed by launch", start_wait, 1'b0);
    start_req = 1; cyc(); start_req = 0;
    want("R5", "immediate launch on free bus", start_go, 1'b1);
    cyc();
    want("R5", "pending cleared", start_wait, 1'b0);

    // R7: clock stall pulse
    scl = 0;
    cyc(LT - 1);
    want("R7", "no pulse before limit", low_tmo, 1'b0);
    want("R3", "scl low clears bus_free", bus_free, 1'b0);
    cyc();
    want("R7", "pulse at limit", low_tmo, 1'b1);
    cyc(30);
    want("R7", "no repeat pulse", low_tmo, 1'b0);

    // R8: high level restarts the count
    scl = 1; cyc(); scl = 0;
    cyc(LT - 1);
    want("R8", "restarted count no pulse", low_tmo, 1'b0);
    cyc();
    want("R8", "restarted count pulse", low_tmo, 1'b1);
    scl = 1; cyc(); scl = 0; cyc(LT / 2);
    scl = 1; cyc(); scl = 0; cyc(LT / 2 + 10);
    want("R8", "split stretches do not add", low_tmo, 1'b0);

    // R9: enable off clears everything
    scl = 1; cyc(FT + 2);
    start_req = 1; free_en = 0; cyc(); start_req = 0; free_en = 1;
    cyc(FT + 1);
    en = 0; cyc(); en = 1;
    want("R9", "bus_free cleared", bus_free, 1'b0);
    want("R9", "start_wait cleared", start_wait, 1'b0);
    cyc(FT);
    want("R9", "idle count restarted", bus_free, 1'b0);
    scl = 0; cyc(LT - 5); en = 0; cyc(); en = 1; cyc(10);
    want("R9", "low count cleared", low_tmo, 1'b0);

    // R10: detector enables
    low_en = 0; cyc(LT + 20);
    want("R10", "low_tmo with low_en off", low_tmo, 1'b0);
    low_en = 1; scl = 1; free_en = 0; cyc(3 * FT);
    want("R10", "bus_free with free_en off", bus_free, 1'b0);
    free_en = 1;

    // random mix against the reference
    for (int k = 0; k < 6000; k++) begin
      if ($urandom % 16 == 0) scl = ~scl;
      if ($urandom % 16 == 0) sda = ~sda;
      tick      = ($urandom % 3 == 0);
      start_req = ($urandom % 40 == 0);
      en        = ($urandom % 200 != 0);
      if ($urandom % 300 == 0) free_en = ~free_en;
      if ($urandom % 300 == 0) low_en  = ~low_en;
      cyc();
    end
    finish_run();
  end

endmodule